// File: doc/BRIEF.md
# Periodic IN Request Scheduler

This block sits on the host side of a USB-style controller. It holds a small number of pending isochronous IN requests and decides, in each frame, which one may go to the packet engine as an IN token. Software programs a channel with a single write. That write carries a channel number, an enable bit, an odd/even frame selector and a multi-count field. Each write with the enable bit set adds one request. A channel that moves several packets per frame is written several times in a row, so its requests sit together in the queue and all target the same frame.

Each request becomes armed at the first start-of-frame pulse after it was queued. From then on it may be issued only while the current frame's parity matches its odd/even selector. The frame parity is taken from bit 0 of the frame number at each start-of-frame pulse. Among eligible requests the oldest goes first. A request that cannot go yet does not hold back younger ones for other channels. A request whose matching frame ends without a token is retired. It is reported on a one-cycle overrun strobe that carries its channel number.

The controller has three states. EMPTY means no request is held. RUN means requests are held and tokens may be offered. FLUSH means expired requests are being reported. The transitions are: EMPTY to RUN when a request is accepted; RUN to FLUSH when a start-of-frame pulse expires at least one request; RUN to EMPTY when the last request leaves; FLUSH to RUN when the last expired request has been reported and others remain; FLUSH to EMPTY when nothing remains.

Top module: `prq_sched`

## Requirements
- R1: After reset, tok_valid and overrun_valid are 0, space_avail is 4 and ovf_sticky is 0.
- R2: A cycle with wr_valid=1 and wr_enable=1 adds exactly one request, whatever the value of wr_mc. A write with wr_enable=0 adds nothing, so space_avail is unchanged.
- R3: At most 4 requests are held. A write with wr_enable=1 while 4 are held is dropped and sets ovf_sticky to 1 until reset. Fullness is judged before any removal in the same cycle.
- R4: A request is armed at the first sof pulse after the cycle in which it was accepted, and is never armed earlier. A request written in the same cycle as a sof pulse waits for the next pulse. The current parity is frame_num[0] sampled at each sof pulse, with 1 meaning odd. An armed request with wr_odd=1 can be issued only in an odd frame, and one with wr_odd=0 only in an even frame.
- R5: tok_valid and tok_chan hold until tok_ready is 1. A cycle with tok_valid=1 and tok_ready=1 removes that request. tok_valid is 0 in any cycle where sof=1.
- R6: tok_chan names the oldest eligible request. Older requests waiting for the other parity do not block it.
- R7: Several requests for one channel written for the same frame are all issued in that frame, back to back when tok_ready stays 1.
- R8: An armed request not issued before the sof pulse that ends its matching frame is retired. From the next cycle, overrun_valid is 1 for one cycle per retired request, oldest first, with overrun_chan naming it. No token is offered while retired requests remain to be reported.
- R9: space_avail always equals 4 minus the number of requests held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Channel characteristics write strobe |
| wr_chan | input | 4 | Channel number of the write |
| wr_enable | input | 1 | Channel enable bit; 1 queues a request |
| wr_odd | input | 1 | 1 targets an odd frame, 0 an even frame |
| wr_mc | input | 2 | Multi-count field; it does not change queueing |
| sof | input | 1 | Start-of-frame pulse |
| frame_num | input | 11 | Frame number, valid while sof is 1 |
| tok_valid | output | 1 | An IN token request is offered |
| tok_chan | output | 4 | Channel of the offered token |
| tok_ready | input | 1 | Packet engine accepts the offered token |
| overrun_valid | output | 1 | One retired request is being reported |
| overrun_chan | output | 4 | Channel of the retired request |
| space_avail | output | 3 | Free request slots, 0 to 4 |
| ovf_sticky | output | 1 | A write was dropped on a full queue |

## Verification
A behavioural queue model in the bench is compared with the outputs in every cycle. The stimulus is a fixed series of frame patterns, each aimed at one rule.

A single odd request with a stalled tok_ready shows both that arming waits for a frame edge and that the offer holds. An even request queued in an even frame must skip the following odd frame, which separates "next frame" from "next frame of matching parity". An even request queued ahead of an odd one tests whether the head request blocks younger requests. A triple write for one channel must produce three tokens in a single frame.

A burst of five writes, followed by a pop and a push in the same cycle, pins down when fullness is judged. Two requests left unserved through their frame must produce two ordered overrun strobes with no token between them.

// File: rtl/prq_pkg.sv
package prq_pkg;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_RUN   = 2'd1,
        S_FLUSH = 2'd2
    } sched_state_e;

endpackage

// File: rtl/prq_pick.sv
module prq_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/prq_store.sv
module prq_store #(
    parameter int DEPTH = 4,
    parameter int CH_W  = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_req,
    input  logic [CH_W-1:0]             push_chan,
    input  logic                        push_odd,
    input  logic                        sof,
    input  logic                        new_odd,
    input  logic                        rm_en,
    input  logic [IDX_W-1:0]            rm_idx,
    output logic [CNT_W-1:0]            cnt,
    output logic [DEPTH-1:0]            elig_mask,
    output logic [DEPTH-1:0]            exp_mask,
    output logic [DEPTH-1:0][CH_W-1:0]  chan_vec,
    output logic [CNT_W-1:0]            nxt_cnt,
    output logic                        nxt_any_exp,
    output logic                        ovf
);

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            odd;
        logic            armed;
        logic            expired;
    } slot_t;

    slot_t            slot_q  [DEPTH];
    slot_t            marked  [DEPTH];
    slot_t            shifted [DEPTH];
    slot_t            slot_d  [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_after_rm;
    logic [CNT_W-1:0] cnt_d;
    logic             cur_odd_q;
    logic             ovf_q;
    logic             full;
    logic             push_ok;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign push_ok = push_req && !full;

    // per-slot views
    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            assign vld[gi]       = (CNT_W'(gi) < cnt_q);
            assign elig_mask[gi] = vld[gi] && slot_q[gi].armed && !slot_q[gi].expired
                                   && (slot_q[gi].odd == cur_odd_q);
            assign exp_mask[gi]  = vld[gi] && slot_q[gi].expired;
            assign chan_vec[gi]  = slot_q[gi].chan;
        end
    endgenerate

    // frame-edge marking, removal with compaction, then append
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            marked[i] = slot_q[i];
            if (sof && vld[i]) begin
                if (slot_q[i].armed && !slot_q[i].expired && (slot_q[i].odd != new_odd)) begin
                    marked[i].expired = 1'b1;
                end else if (!slot_q[i].armed) begin
                    marked[i].armed = 1'b1;
                end
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (rm_en && (IDX_W'(i) >= rm_idx)) begin
                shifted[i] = (i < DEPTH - 1) ? marked[(i < DEPTH - 1) ? i + 1 : i] : '0;
            end else begin
                shifted[i] = marked[i];
            end
        end
        cnt_after_rm = cnt_q - CNT_W'(rm_en);
        for (int i = 0; i < DEPTH; i++) begin
            if (push_ok && (CNT_W'(i) == cnt_after_rm)) begin
                slot_d[i] = '{chan: push_chan, odd: push_odd, armed: 1'b0, expired: 1'b0};
            end else begin
                slot_d[i] = shifted[i];
            end
        end
        cnt_d       = cnt_after_rm + CNT_W'(push_ok);
        nxt_any_exp = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            nxt_any_exp = nxt_any_exp | slot_d[i].expired;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            cnt_q     <= '0;
            cur_odd_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
            cnt_q <= cnt_d;
            if (sof) cur_odd_q <= new_odd;
            if (push_req && full) ovf_q <= 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign nxt_cnt = cnt_d;
    assign ovf     = ovf_q;

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    a_r2_push_one: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !full && !rm_en) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r3_full_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> (ovf_q && (cnt_q <= $past(cnt_q))));

endmodule

// File: rtl/prq_ctrl.sv
module prq_ctrl
    import prq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             tok_ready,
    input  logic [DEPTH-1:0] elig_mask,
    input  logic             elig_found,
    input  logic [IDX_W-1:0] elig_idx,
    input  logic             exp_found,
    input  logic [IDX_W-1:0] exp_idx,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic             nxt_any_exp,
    output logic             tok_valid,
    output logic             overrun_valid,
    output logic             rm_en,
    output logic [IDX_W-1:0] rm_idx
);

    sched_state_e state_q;
    sched_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_EMPTY: begin
                if (nxt_cnt != '0) state_d = S_RUN;
            end
            S_RUN: begin
                if (nxt_any_exp)         state_d = S_FLUSH;
                else if (nxt_cnt == '0)  state_d = S_EMPTY;
            end
            S_FLUSH: begin
                if (!nxt_any_exp) state_d = (nxt_cnt != '0) ? S_RUN : S_EMPTY;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    always_comb begin
        tok_valid     = 1'b0;
        overrun_valid = 1'b0;
        unique case (state_q)
            S_EMPTY: ;
            S_RUN:   tok_valid     = elig_found && !sof;
            S_FLUSH: overrun_valid = 1'b1;
            default: ;
        endcase
        rm_en  = overrun_valid || (tok_valid && tok_ready);
        rm_idx = overrun_valid ? exp_idx : elig_idx;
    end

    a_r8_flush_has_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH) |-> exp_found);

    a_r8_run_no_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_FLUSH) |-> !exp_found);

    a_r1_empty_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMPTY) |-> (cnt == '0));

    a_r6_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> ((elig_mask & ((DEPTH'(1) << elig_idx) - DEPTH'(1))) == '0));

endmodule

// File: rtl/prq_sched.sv
module prq_sched #(
    parameter  int DEPTH = 4,
    parameter  int CH_W  = 4,
    parameter  int FN_W  = 11,
    parameter  int MC_W  = 2,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic             wr_enable,
    input  logic             wr_odd,
    input  logic [MC_W-1:0]  wr_mc,
    input  logic             sof,
    input  logic [FN_W-1:0]  frame_num,
    output logic             tok_valid,
    output logic [CH_W-1:0]  tok_chan,
    input  logic             tok_ready,
    output logic             overrun_valid,
    output logic [CH_W-1:0]  overrun_chan,
    output logic [CNT_W-1:0] space_avail,
    output logic             ovf_sticky
);

    logic [CNT_W-1:0]           cnt;
    logic [CNT_W-1:0]           nxt_cnt;
    logic                       nxt_any_exp;
    logic [DEPTH-1:0]           elig_mask;
    logic [DEPTH-1:0]           exp_mask;
    logic [DEPTH-1:0][CH_W-1:0] chan_vec;
    logic                       elig_found;
    logic [IDX_W-1:0]           elig_idx;
    logic                       exp_found;
    logic [IDX_W-1:0]           exp_idx;
    logic                       rm_en;
    logic [IDX_W-1:0]           rm_idx;
    logic                       unused_bits;

    // multi-count and upper frame bits do not steer queueing
    assign unused_bits = ^{wr_mc, frame_num[FN_W-1:1]};

    prq_store #(.DEPTH(DEPTH), .CH_W(CH_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_req   (wr_valid && wr_enable),
        .push_chan  (wr_chan),
        .push_odd   (wr_odd),
        .sof        (sof),
        .new_odd    (frame_num[0]),
        .rm_en      (rm_en),
        .rm_idx     (rm_idx),
        .cnt        (cnt),
        .elig_mask  (elig_mask),
        .exp_mask   (exp_mask),
        .chan_vec   (chan_vec),
        .nxt_cnt    (nxt_cnt),
        .nxt_any_exp(nxt_any_exp),
        .ovf        (ovf_sticky)
    );

    prq_pick #(.N(DEPTH), .IW(IDX_W)) u_pick_elig (
        .mask (elig_mask),
        .found(elig_found),
        .idx  (elig_idx)
    );

    prq_pick #(.N(DEPTH), .IW(IDX_W)) u_pick_exp (
        .mask (exp_mask),
        .found(exp_found),
        .idx  (exp_idx)
    );

    prq_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof          (sof),
        .tok_ready    (tok_ready),
        .elig_mask    (elig_mask),
        .elig_found   (elig_found),
        .elig_idx     (elig_idx),
        .exp_found    (exp_found),
        .exp_idx      (exp_idx),
        .cnt          (cnt),
        .nxt_cnt      (nxt_cnt),
        .nxt_any_exp  (nxt_any_exp),
        .tok_valid    (tok_valid),
        .overrun_valid(overrun_valid),
        .rm_en        (rm_en),
        .rm_idx       (rm_idx)
    );

    assign tok_chan     = chan_vec[elig_idx];
    assign overrun_chan = chan_vec[exp_idx];
    assign space_avail  = CNT_W'(DEPTH) - cnt;

endmodule

// File: tb/prq_sched_test.sv
`timescale 1ns/100ps
module prq_sched_test;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [3:0] wr_chan = '0;
    logic       wr_enable = 1'b0;
    logic       wr_odd = 1'b0;
    logic [1:0] wr_mc = '0;
    logic       sof = 1'b0;
    logic [10:0] frame_num = '0;
    logic       tok_valid;
    logic [3:0] tok_chan;
    logic       tok_ready = 1'b0;
    logic       overrun_valid;
    logic [3:0] overrun_chan;
    logic [2:0] space_avail;
    logic       ovf_sticky;

    int n_chk = 0;
    int n_fail = 0;
    int fn = 0;

    typedef struct packed {
        logic [3:0] chan;
        logic       odd;
        logic       armed;
        logic       expd;
    } req_t;

    req_t q[$];
    bit   m_ovf = 1'b0;
    bit   m_cur = 1'b0;

    always #2.5 clk = ~clk;

    prq_sched uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_enable(wr_enable), .wr_odd(wr_odd), .wr_mc(wr_mc), .sof(sof),
        .frame_num(frame_num), .tok_valid(tok_valid), .tok_chan(tok_chan),
        .tok_ready(tok_ready), .overrun_valid(overrun_valid),
        .overrun_chan(overrun_chan), .space_avail(space_avail), .ovf_sticky(ovf_sticky)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // one clock: compare against model, advance model at the edge
    task automatic cyc();
        int   ti;
        int   oi;
        int   rm;
        bit   tv;
        bit   ov;
        bit   full;
        req_t t;
        #0.5;
        ti = -1;
        oi = -1;
        for (int k = 0; k < q.size(); k++) if (q[k].expd && oi < 0) oi = k;
        ov = (oi >= 0);
        if (!ov && !sof)
            for (int k = 0; k < q.size(); k++)
                if (ti < 0 && q[k].armed && !q[k].expd && q[k].odd == m_cur) ti = k;
        tv = (ti >= 0);
        chk("R5 tok_valid", int'(tok_valid), int'(tv));
        if (tv) chk("R6 tok_chan", int'(tok_chan), int'(q[ti].chan));
        chk("R8 overrun_valid", int'(overrun_valid), int'(ov));
        if (ov) chk("R8 overrun_chan", int'(overrun_chan), int'(q[oi].chan));
        chk("R9 space_avail", int'(space_avail), DEPTH - q.size());
        chk("R3 ovf_sticky", int'(ovf_sticky), int'(m_ovf));
        @(posedge clk);
        full = (q.size() == DEPTH);
        rm = -1;
        if (ov) rm = oi;
        else if (tv && tok_ready) rm = ti;
        if (sof) begin
            for (int k = 0; k < q.size(); k++) begin
                t = q[k];
                if (t.armed && !t.expd && t.odd != frame_num[0]) t.expd = 1'b1;
                else if (!t.armed) t.armed = 1'b1;
                q[k] = t;
            end
            m_cur = frame_num[0];
        end
        if (rm >= 0) q.delete(rm);
        if (wr_valid && wr_enable) begin
            if (full) m_ovf = 1'b1;
            else q.push_back('{chan: wr_chan, odd: wr_odd, armed: 1'b0, expd: 1'b0});
        end
        @(negedge clk);
        wr_valid = 1'b0;
        sof = 1'b0;
        #1;
    endtask

    task automatic push(int ch, bit en, bit odd, int mc);
        wr_valid = 1'b1; wr_chan = 4'(ch); wr_enable = en; wr_odd = odd; wr_mc = 2'(mc);
        cyc();
    endtask

    task automatic new_frame();
        fn++;
        frame_num = 11'(fn);
        sof = 1'b1;
        cyc();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic take();
        tok_ready = 1'b1;
        cyc();
        tok_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 tok_valid", int'(tok_valid), 0);
        chk("R1 overrun_valid", int'(overrun_valid), 0);
        chk("R1 space_avail", int'(space_avail), 4);
        chk("R1 ovf_sticky", int'(ovf_sticky), 0);
        rst_n = 1'b1;
        idle(2);

        // single odd request, stalled acceptance
        push(3, 1, 1, 0);
        chk("R2 space after push", int'(space_avail), 3);
        idle(2);
        chk("R4 not armed before sof", int'(tok_valid), 0);
        new_frame();                                   // frame 1, odd
        chk("R4 odd request in odd frame", int'(tok_valid), 1);
        chk("R4 channel", int'(tok_chan), 3);
        idle(3);
        chk("R5 held while not ready", int'(tok_valid), 1);
        take();
        chk("R5 popped on ready", int'(space_avail), 4);

        // even request skips the odd frame
        push(4, 1, 0, 0);
        new_frame();                                   // frame 2
        chk("R4 even in even frame", int'(tok_chan), 4);
        take();
        push(6, 1, 0, 0);
        new_frame();                                   // frame 3
        chk("R4 even waits in odd frame", int'(tok_valid), 0);
        new_frame();                                   // frame 4
        chk("R4 even issued next even frame", int'(tok_chan), 6);
        take();

        // non-matching head does not block
        push(1, 1, 0, 0);
        push(2, 1, 1, 0);
        new_frame();                                   // frame 5
        chk("R6 younger odd passes older even", int'(tok_chan), 2);
        take();
        chk("R6 older even still waits", int'(tok_valid), 0);
        new_frame();                                   // frame 6
        chk("R6 older even issued", int'(tok_chan), 1);
        take();

        // high bandwidth: three for one channel
        push(5, 1, 1, 3);
        push(5, 1, 1, 3);
        push(5, 1, 1, 3);
        new_frame();                                   // frame 7
        tok_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            chk("R7 burst token valid", int'(tok_valid), 1);
            chk("R7 burst channel", int'(tok_chan), 5);
            cyc();
        end
        tok_ready = 1'b0;
        chk("R7 all three issued", int'(space_avail), 4);

        // disabled write
        push(7, 0, 1, 2);
        chk("R2 disabled write ignored", int'(space_avail), 4);
        new_frame();                                   // frame 8
        new_frame();                                   // frame 9
        chk("R2 nothing to issue", int'(tok_valid), 0);

        // fill and overflow
        for (int i = 0; i < 4; i++) push(8 + i, 1, 1, 0);
        chk("R3 full", int'(space_avail), 0);
        chk("R3 no overflow yet", int'(ovf_sticky), 0);
        push(12, 1, 1, 0);
        chk("R3 overflow flag", int'(ovf_sticky), 1);
        chk("R3 still four", int'(space_avail), 0);
        new_frame();                                   // frame 10
        new_frame();                                   // frame 11
        tok_ready = 1'b1;
        push(13, 1, 1, 0);
        chk("R3 push dropped despite pop", int'(space_avail), 1);
        idle(3);
        tok_ready = 1'b0;
        chk("R3 drained", int'(space_avail), 4);
        chk("R3 flag sticky", int'(ovf_sticky), 1);

        // missed frame -> overrun
        push(14, 1, 1, 0);
        push(15, 1, 1, 0);
        new_frame();                                   // frame 12
        new_frame();                                   // frame 13
        idle(1);
        chk("R8 offered in its frame", int'(tok_chan), 14);
        new_frame();                                   // frame 14
        chk("R8 first overrun", int'(overrun_valid), 1);
        chk("R8 first overrun channel", int'(overrun_chan), 14);
        chk("R8 no token during flush", int'(tok_valid), 0);
        cyc();
        chk("R8 second overrun channel", int'(overrun_chan), 15);
        cyc();
        chk("R8 flush done", int'(overrun_valid), 0);
        chk("R9 empty again", int'(space_avail), 4);
        idle(2);

        summary();
        $finish;
    end

endmodule